// File: doc/BRIEF.md
# Configuration Bitstream Serialiser

This block builds a complete configuration stream and sends it out one bit per clock. A single `start` pulse begins the stream. The block first sends a header: a run of one bits, a four-bit sync code, a 24-bit count of every bit in the stream, and a four-bit spacer of ones. It then sends the payload frames. Last comes a fixed eight-bit closing code. The caller can ask for extra leading ones. The count in the header always includes them, so the block works out the total length before any payload has arrived.

Frame payloads come from an upstream source, one whole frame word at a time, over a valid/ready handshake. Each frame goes out as a zero start bit, then the payload with its most significant bit first, then a constant four-bit check field. If the next frame word is not yet available, the serial output pauses and `serValid` stays low until the word arrives. `FRAME_BITS` sets the payload bits per frame, `NUM_FRAMES` sets the number of frames, and `LEAD_W` sets the width of the extra-ones request.

Top module: `cfg_stream_fmt`

## Requirements
- R1: After reset, `busy`, `serValid` and `frameReady` are all low.
- R2: A stream starts with 8+E one bits, where E is the value on `extraOnes` in the cycle `start` is accepted.
- R3: The leading ones are followed by the sync code, sent in the order 0,0,1,0.
- R4: Next comes a 24-bit length, most significant bit first, equal to 48 + E + NUM_FRAMES*(FRAME_BITS+5).
- R5: After the length, four one bits are sent.
- R6: Each frame goes out as a 0 bit, then the FRAME_BITS payload bits with the most significant bit first, then the check field 0,1,1,0.
- R7: After the last frame, the closing code 0,1,1,1,1,1,1,1 is sent. The number of bits sent with `serValid` high equals the length sent in R4.
- R8: `frameReady` is high only while the block waits to start a frame. A word is taken on a clock edge where both `frameValid` and `frameReady` are high. A `frameValid` that arrives during the header is not consumed.
- R9: While `frameReady` is high and `frameValid` is low, `serValid` is low. When the word arrives, the stream carries on with no bit lost or repeated.
- R10: `busy` rises in the cycle after `start` is accepted. It stays high through the last closing bit and is low in the cycle after that bit.
- R11: A `start` pulse while `busy` is high is ignored. The running stream, including its length and its leading-ones count, does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin a stream while idle |
| extraOnes | input | LEAD_W | Number of extra leading one bits, sampled at start |
| frameData | input | FRAME_BITS | Payload word of the next frame |
| frameValid | input | 1 | The payload word is present |
| frameReady | output | 1 | The block waits for a payload word |
| serOut | output | 1 | Serial stream bit |
| serValid | output | 1 | `serOut` carries a stream bit this cycle |
| busy | output | 1 | A stream is in progress |

## Verification
A phase counter that is off by one, or a frame counter that ends too early or too late, moves every later bit. The first wrong bit appears at the port in the same cycle as the slip, and the total bit count then no longer matches the length the block sent. A wrong length constant shows within the 24 length bits, before any frame has been requested. A handshake fault shows in one of three ways: a bit that is valid while the block waits for data, a lost frame, or `busy` that never drops. The scoreboard catches the first of these at the first stalled cycle.

// File: rtl/cfg_fmt_pkg.sv
package cfg_fmt_pkg;

  localparam int HDR_ONES  = 8;
  localparam int PRE_BITS  = 4;
  localparam int LEN_BITS  = 24;
  localparam int SEP_BITS  = 4;
  localparam int CHK_BITS  = 4;
  localparam int POST_BITS = 8;

  // Bit i of each code is the i-th bit sent
  localparam logic [PRE_BITS-1:0]  PRE_SEQ  = 4'b0100;
  localparam logic [CHK_BITS-1:0]  CHK_SEQ  = 4'b0110;
  localparam logic [POST_BITS-1:0] POST_SEQ = 8'b1111_1110;

  typedef enum logic [3:0] {
    PH_IDLE, PH_LEAD, PH_PRE, PH_LEN, PH_SEP,
    PH_FSTART, PH_FDATA, PH_FCHK, PH_POST
  } phase_e;

  typedef struct packed {
    logic       loadLen;
    logic       shiftLen;
    logic       loadFrame;
    logic       shiftFrame;
    phase_e     phase;
    logic [4:0] bitIdx;
  } strobe_t;

endpackage

// File: rtl/cfg_fmt_ctrl.sv
module cfg_fmt_ctrl
  import cfg_fmt_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int NUM_FRAMES = 4,
  parameter int LEAD_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEAD_W-1:0] extraOnes,
  input  logic              frameValid,
  output strobe_t           st,
  output logic              busy,
  output logic              frameReady,
  output logic              serValid
);

  localparam int LEAD_MAX = HDR_ONES + (1 << LEAD_W) - 1;
  localparam int CNT_M1   = (LEAD_MAX > FRAME_BITS) ? LEAD_MAX : FRAME_BITS;
  localparam int CNT_MAX  = (CNT_M1 > LEN_BITS) ? CNT_M1 : LEN_BITS;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);
  localparam int FRM_W    = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;

  phase_e           ph, phNext;
  logic [CNT_W-1:0] cnt, phaseLen, leadLen;
  logic [FRM_W-1:0] frmCnt;
  logic             lastBit, lastFrame;

  always_comb begin
    case (ph)
      PH_LEAD:  phaseLen = leadLen;
      PH_PRE:   phaseLen = CNT_W'(PRE_BITS);
      PH_LEN:   phaseLen = CNT_W'(LEN_BITS);
      PH_SEP:   phaseLen = CNT_W'(SEP_BITS);
      PH_FDATA: phaseLen = CNT_W'(FRAME_BITS);
      PH_FCHK:  phaseLen = CNT_W'(CHK_BITS);
      PH_POST:  phaseLen = CNT_W'(POST_BITS);
      default:  phaseLen = CNT_W'(1);
    endcase
  end

  assign lastBit    = (cnt == phaseLen - CNT_W'(1));
  assign lastFrame  = (frmCnt == FRM_W'(NUM_FRAMES - 1));
  assign busy       = (ph != PH_IDLE);
  assign frameReady = (ph == PH_FSTART);
  assign serValid   = busy && (frameReady ? frameValid : 1'b1);

  always_comb begin
    case (ph)
      PH_LEAD:   phNext = PH_PRE;
      PH_PRE:    phNext = PH_LEN;
      PH_LEN:    phNext = PH_SEP;
      PH_SEP:    phNext = PH_FSTART;
      PH_FSTART: phNext = PH_FDATA;
      PH_FDATA:  phNext = PH_FCHK;
      PH_FCHK:   phNext = lastFrame ? PH_POST : PH_FSTART;
      default:   phNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cnt     <= '0;
      frmCnt  <= '0;
      leadLen <= '0;
    end else if (ph == PH_IDLE) begin
      if (start) begin
        ph      <= PH_LEAD;
        cnt     <= '0;
        frmCnt  <= '0;
        leadLen <= CNT_W'(HDR_ONES) + CNT_W'(extraOnes);
      end
    end else if (serValid) begin
      if (lastBit) begin
        ph  <= phNext;
        cnt <= '0;
        if (ph == PH_FCHK && !lastFrame) frmCnt <= frmCnt + FRM_W'(1);
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    st            = '0;
    st.loadLen    = (ph == PH_IDLE) && start;
    st.shiftLen   = (ph == PH_LEN);
    st.loadFrame  = frameReady && frameValid;
    st.shiftFrame = (ph == PH_FDATA);
    st.phase      = ph;
    st.bitIdx     = cnt[4:0];
  end

  // R9
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frameReady && !frameValid) |-> !serValid);

  // R8
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frameReady |-> busy);

  // R10
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_POST && lastBit) |=> !busy);

  // R11
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (ph != PH_LEAD || $past(ph) == PH_LEAD));

  // R6
  frame_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_FCHK && lastBit && serValid && !lastFrame) |=> (ph == PH_FSTART));

endmodule

// File: rtl/cfg_fmt_dp.sv
module cfg_fmt_dp
  import cfg_fmt_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int NUM_FRAMES = 4,
  parameter int LEAD_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  strobe_t               st,
  input  logic [LEAD_W-1:0]     extraOnes,
  input  logic [FRAME_BITS-1:0] frameData,
  output logic                  serOut
);

  localparam int FRAME_TOTAL = 1 + FRAME_BITS + CHK_BITS;
  localparam int STREAM_BASE = HDR_ONES + PRE_BITS + LEN_BITS + SEP_BITS
                             + POST_BITS + NUM_FRAMES * FRAME_TOTAL;

  logic [LEN_BITS-1:0]   lenSh;
  logic [FRAME_BITS-1:0] frameSh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lenSh   <= '0;
      frameSh <= '0;
    end else begin
      if (st.loadLen)        lenSh <= LEN_BITS'(STREAM_BASE) + LEN_BITS'(extraOnes);
      else if (st.shiftLen)  lenSh <= lenSh << 1;
      if (st.loadFrame)        frameSh <= frameData;
      else if (st.shiftFrame)  frameSh <= frameSh << 1;
    end
  end

  always_comb begin
    case (st.phase)
      PH_LEAD, PH_SEP: serOut = 1'b1;
      PH_PRE:          serOut = PRE_SEQ[st.bitIdx[1:0]];
      PH_LEN:          serOut = lenSh[LEN_BITS-1];
      PH_FDATA:        serOut = frameSh[FRAME_BITS-1];
      PH_FCHK:         serOut = CHK_SEQ[st.bitIdx[1:0]];
      PH_POST:         serOut = POST_SEQ[st.bitIdx[2:0]];
      default:         serOut = 1'b0;
    endcase
  end

  // R4
  len_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st.phase == PH_SEP) |-> (lenSh == '0));

  // R6
  frame_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st.phase == PH_FCHK) |-> (frameSh == '0));

endmodule

// File: rtl/cfg_stream_fmt.sv
module cfg_stream_fmt
  import cfg_fmt_pkg::*;
#(
  parameter int FRAME_BITS = 8,
  parameter int NUM_FRAMES = 4,
  parameter int LEAD_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [LEAD_W-1:0]     extraOnes,
  input  logic [FRAME_BITS-1:0] frameData,
  input  logic                  frameValid,
  output logic                  frameReady,
  output logic                  serOut,
  output logic                  serValid,
  output logic                  busy
);

  strobe_t st;

  cfg_fmt_ctrl #(
    .FRAME_BITS(FRAME_BITS), .NUM_FRAMES(NUM_FRAMES), .LEAD_W(LEAD_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .extraOnes(extraOnes),
    .frameValid(frameValid), .st(st), .busy(busy),
    .frameReady(frameReady), .serValid(serValid)
  );

  cfg_fmt_dp #(
    .FRAME_BITS(FRAME_BITS), .NUM_FRAMES(NUM_FRAMES), .LEAD_W(LEAD_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .extraOnes(extraOnes),
    .frameData(frameData), .serOut(serOut)
  );

endmodule

// File: tb/cfg_stream_fmt_tb.sv
module cfg_stream_fmt_tb;

  localparam int FB = 8;
  localparam int NF = 4;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [LW-1:0] extraOnes = '0;
  logic [FB-1:0] frameData = '0;
  logic          frameValid = 1'b0;
  logic          frameReady, serOut, serValid, busy;

  int checks = 0;
  int failures = 0;
  int bitsSeen = 0;
  int expQ[$];   // entry = tag*2 + bit

  always #4 clk = ~clk;

  cfg_stream_fmt #(.FRAME_BITS(FB), .NUM_FRAMES(NF), .LEAD_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .extraOnes(extraOnes),
    .frameData(frameData), .frameValid(frameValid), .frameReady(frameReady),
    .serOut(serOut), .serValid(serValid), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int tag, input int b);
    expQ.push_back(tag * 2 + b);
  endtask

  // Monitor: pop expected bits as valid bits appear
  always @(negedge clk) begin
    if (rst_n) begin
      if (frameReady && !frameValid)
        check(serValid == 1'b0, "R9 stall", int'(serValid), 0);
      if (serValid) begin
        bitsSeen++;
        check(busy == 1'b1, "R10 busy during bit", int'(busy), 1);
        if (expQ.size() == 0) begin
          check(1'b0, "R7 extra bit", 1, 0);
        end else begin
          automatic int e = expQ.pop_front();
          checks++;
          if (serOut !== 1'(e % 2)) begin
            failures++;
            $display("FAIL R%0d stream bit actual=%0d expected=%0d", e / 2, serOut, e % 2);
          end
        end
      end
    end
  end

  task automatic runStream(input int e, input int stallCyc, input bit poke,
                           input logic [FB-1:0] base, input logic [FB-1:0] step);
    logic [FB-1:0] frm[NF];
    int lenVal;
    lenVal = 48 + e + NF * (FB + 5);
    for (int i = 0; i < NF; i++) frm[i] = base + FB'(i) * step;
    // R2 leading ones
    for (int i = 0; i < 8 + e; i++) push(2, 1);
    // R3 sync code
    push(3, 0); push(3, 0); push(3, 1); push(3, 0);
    // R4 length, MSB first
    for (int i = 23; i >= 0; i--) push(4, (lenVal >> i) & 1);
    // R5 spacer
    for (int i = 0; i < 4; i++) push(5, 1);
    // R6 frames
    for (int f = 0; f < NF; f++) begin
      push(6, 0);
      for (int i = FB - 1; i >= 0; i--) push(6, int'(frm[f][i]));
      push(6, 0); push(6, 1); push(6, 1); push(6, 0);
    end
    // R7 closing code
    push(7, 0);
    for (int i = 0; i < 7; i++) push(7, 1);

    bitsSeen = 0;
    @(posedge clk); #1;
    extraOnes = LW'(e); start = 1'b1;
    if (stallCyc == 0) begin frameValid = 1'b1; frameData = frm[0]; end
    @(posedge clk); #1;
    start = 1'b0;
    @(negedge clk);
    check(busy == 1'b1, "R10 busy after start", int'(busy), 1);
    check(frameReady == 1'b0, "R8 no ready in header", int'(frameReady), 0);
    if (poke) begin
      repeat (6) @(posedge clk);
      #1; start = 1'b1; extraOnes = LW'(e) ^ LW'(5);
      @(posedge clk); #1; start = 1'b0; extraOnes = LW'(e);
    end
    for (int f = 0; f < NF; f++) begin
      if (stallCyc > 0) begin
        do @(negedge clk); while (!frameReady);
        repeat (stallCyc) @(negedge clk);
        @(posedge clk); #1;
      end
      frameValid = 1'b1; frameData = frm[f];
      forever begin
        @(negedge clk);
        if (frameReady) break;
      end
      @(posedge clk); #1;
      frameValid = 1'b0;
    end
    do @(negedge clk); while (busy);
    check(expQ.size() == 0, "R7 all bits sent", expQ.size(), 0);
    check(bitsSeen == lenVal, "R7 bit count equals length", bitsSeen, lenVal);
    check(frameReady == 1'b0, "R8 ready low when idle", int'(frameReady), 0);
    check(serValid == 1'b0, "R10 no bit after end", int'(serValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(serValid == 1'b0, "R1 serValid", int'(serValid), 0);
    check(frameReady == 1'b0, "R1 frameReady", int'(frameReady), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R1 idle after reset", int'(busy), 0);

    runStream(0, 0, 1'b0, 8'hA5, 8'h3C);   // R2 R6 back-to-back frames
    runStream(15, 3, 1'b0, 8'h12, 8'h47);  // R9 stalls, max extra ones
    runStream(5, 1, 1'b1, 8'hC3, 8'h11);   // R11 restart while busy
    runStream(3, 0, 1'b0, 8'hFF, 8'h00);   // R6 all-ones payload
    runStream(1, 2, 1'b0, 8'h00, 8'h00);   // R6 all-zeros payload

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog busy=%0d expected=0", busy);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule